// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block is a small 2D drawing engine for a frame store that holds one 16-bit pixel per halfword. A host feeds it a stream of 32-bit command words over a valid/ready handshake. Each word either loads one operation parameter into a register or starts an operation. Parameter words set the destination corner, the source corner, the rectangle width and height, and the fill colour. Start words launch either a solid fill or a copy. Every other opcode is dropped.

During an operation the engine makes one access per clock cycle on a synchronous memory port. It walks the rectangle row by row from the top-left pixel. A fill writes the colour once per pixel. A copy reads the source pixel in one cycle and writes that data to the destination pixel in the next cycle. The line pitch comes from a horizontal pixel count input. At the end of an operation the engine gives a one-cycle done pulse, and it also pulses an interrupt line if the start word asked for one.

Top module: `rect_blit_engine`

## Requirements
- R1: Bits 31:24 of a command word select the action. Opcode 0x0B loads the colour from bits 15:0 (RGB565: red in 15:11, green in 10:5, blue in 4:0). Opcode 0x0E loads width minus one from bits 9:0. Opcode 0x0F loads height minus one from bits 9:0. Opcode 0x0C loads the destination byte address and 0x0D loads the source byte address, both from bits 23:0 with bit 0 forced to zero. Every memory address the engine issues is even.
- R2: Opcode 0x23 starts a fill of (width+1)×(height+1) pixels. Pixel (x,y) is written with the colour at byte address dst + (y·line_pixels + x)·2. Writes go in raster order, one per cycle, and the first one occurs in the cycle after the start word is accepted.
- R3: Opcode 0x21 starts a copy. For each pixel in raster order, the engine reads src + (y·line_pixels + x)·2 in one cycle. In the next cycle it writes the data returned by that read to the matching destination address.
- R4: `busy` is high from the cycle after a start word is accepted through the cycle of the last access. `cmd_ready` is low whenever `busy` is high. No memory access occurs while `busy` is low.
- R5: `done` pulses for exactly one cycle, in the cycle after the last access. That is N cycles after acceptance for a fill and 2N for a copy, where N is the pixel count. `irq` pulses together with `done` only if bit 1 of the start word was set.
- R6: Parameter registers keep their values across operations, so a later start word reuses every parameter that was not reloaded.
- R7: Words with any other opcode are accepted and discarded, with no effect on parameters or activity. This includes the out-of-scope start codes 0x22 and 0x24. Start-word bits other than bit 1 are ignored.
- R8: After reset, `busy`, `done`, `irq` and `mem_en` are low, `cmd_ready` is high, and all parameters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word present |
| cmd_word | input | 32 | Opcode in 31:24, parameter below |
| cmd_ready | output | 1 | Engine can take a command word |
| line_pixels | input | LINE_W | Pixels per frame-store line |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address (always even) |
| mem_wdata | output | 16 | Pixel written |
| mem_rdata | input | 16 | Read data, one cycle after a read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| irq | output | 1 | Interrupt pulse for start words that request it |

## Verification
The checker watches on every cycle:
- that addresses stay even;
- that the engine is silent on the memory port while idle;
- that a start word raises `busy` and a dropped opcode does not;
- that every copy read is followed at once by a write;
- the shape of the `done` and `irq` pulses.

Only the bench scenarios can show the following:
- the exact address and data sequence of the raster walk across different line pitches and rectangle sizes;
- that copied data matches the source contents;
- the completion cycle count;
- that parameters survive between operations and are untouched by dropped words.

// File: rtl/rbe_pkg.sv
package rbe_pkg;

    localparam int CMD_W  = 32;
    localparam int OP_W   = 8;
    localparam int ADDR_W = 24;
    localparam int DIM_W  = 10;
    localparam int PIX_W  = 16;
    localparam int GO_IRQ_BIT = 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DIM_W-1:0]  dim_t;
    typedef logic [PIX_W-1:0]  pix_t;

    typedef enum logic [OP_W-1:0] {
        OP_COLOUR  = 8'h0B,
        OP_DST     = 8'h0C,
        OP_SRC     = 8'h0D,
        OP_WIDTH   = 8'h0E,
        OP_HEIGHT  = 8'h0F,
        OP_COPY_GO = 8'h21,
        OP_FILL_GO = 8'h23
    } opcode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_READ,
        ST_WRITE
    } walk_state_e;

    typedef enum logic {
        JOB_FILL,
        JOB_COPY
    } job_e;

    typedef struct packed {
        addr_t dst;
        addr_t src;
        dim_t  w_m1;
        dim_t  h_m1;
        pix_t  colour;
    } shape_t;

    typedef struct packed {
        logic fire;
        job_e kind;
        logic irq_req;
    } launch_t;

    function automatic addr_t halfword_align(logic [CMD_W-1:0] word);
        return {word[ADDR_W-1:1], 1'b0};
    endfunction

endpackage

// File: rtl/rbe_cmd_decode.sv
module rbe_cmd_decode
    import rbe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             accept_en,
    input  logic [CMD_W-1:0] cmd_word,
    output shape_t           shape,
    output launch_t          launch
);

    logic            take;
    logic [OP_W-1:0] op;

    assign take = cmd_valid && accept_en;
    assign op   = cmd_word[CMD_W-1 -: OP_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            shape <= '0;
        end else if (take) begin
            case (op)
                OP_COLOUR: shape.colour <= cmd_word[PIX_W-1:0];
                OP_DST:    shape.dst    <= halfword_align(cmd_word);
                OP_SRC:    shape.src    <= halfword_align(cmd_word);
                OP_WIDTH:  shape.w_m1   <= cmd_word[DIM_W-1:0];
                OP_HEIGHT: shape.h_m1   <= cmd_word[DIM_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        launch = '{fire: 1'b0, kind: JOB_FILL, irq_req: 1'b0};
        if (take) begin
            case (op)
                OP_FILL_GO: launch = '{fire: 1'b1, kind: JOB_FILL,
                                       irq_req: cmd_word[GO_IRQ_BIT]};
                OP_COPY_GO: launch = '{fire: 1'b1, kind: JOB_COPY,
                                       irq_req: cmd_word[GO_IRQ_BIT]};
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rbe_cursor.sv
module rbe_cursor
    import rbe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  addr_t load_addr,
    input  logic  step_pix,
    input  logic  step_row,
    input  addr_t stride,
    output addr_t ptr
);

    addr_t row_base;
    addr_t next_row;

    assign next_row = row_base + stride;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_base <= '0;
            ptr      <= '0;
        end else if (load) begin
            row_base <= load_addr;
            ptr      <= load_addr;
        end else if (step_row) begin
            row_base <= next_row;
            ptr      <= next_row;
        end else if (step_pix) begin
            ptr <= ptr + ADDR_W'(2);
        end
    end

endmodule

// File: rtl/rbe_walker.sv
module rbe_walker
    import rbe_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  launch_t           launch,
    input  shape_t            shape,
    input  logic [LINE_W-1:0] line_pixels,
    input  pix_t              mem_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output addr_t             mem_addr,
    output pix_t              mem_wdata,
    output logic              busy,
    output logic              done,
    output logic              irq
);

    localparam int NCUR    = 2;
    localparam int CUR_DST = 0;
    localparam int CUR_SRC = 1;

    walk_state_e state;
    dim_t        x_cnt, y_cnt, w_lim, h_lim;
    pix_t        colour_q;
    logic        irq_q;
    logic        advance, last_col, last_row, finish;
    logic        cur_load, step_pix, step_row;
    addr_t       stride;
    addr_t       cur_base [NCUR];
    addr_t       cur_ptr  [NCUR];

    assign stride   = ADDR_W'({line_pixels, 1'b0});
    assign advance  = (state == ST_FILL) || (state == ST_WRITE);
    assign last_col = (x_cnt == w_lim);
    assign last_row = (y_cnt == h_lim);
    assign finish   = advance && last_col && last_row;
    assign cur_load = launch.fire && (state == ST_IDLE);
    assign step_pix = advance && !last_col;
    assign step_row = advance && last_col && !last_row;

    assign cur_base[CUR_DST] = shape.dst;
    assign cur_base[CUR_SRC] = shape.src;

    for (genvar g = 0; g < NCUR; g++) begin : g_cursor
        rbe_cursor u_cursor (
            .clk       (clk),
            .rst       (rst),
            .load      (cur_load),
            .load_addr (cur_base[g]),
            .step_pix  (step_pix),
            .step_row  (step_row),
            .stride    (stride),
            .ptr       (cur_ptr[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            x_cnt    <= '0;
            y_cnt    <= '0;
            w_lim    <= '0;
            h_lim    <= '0;
            colour_q <= '0;
            irq_q    <= 1'b0;
            done     <= 1'b0;
            irq      <= 1'b0;
        end else begin
            done <= 1'b0;
            irq  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (launch.fire) begin
                        state    <= (launch.kind == JOB_COPY) ? ST_READ : ST_FILL;
                        x_cnt    <= '0;
                        y_cnt    <= '0;
                        w_lim    <= shape.w_m1;
                        h_lim    <= shape.h_m1;
                        colour_q <= shape.colour;
                        irq_q    <= launch.irq_req;
                    end
                end
                ST_READ: state <= ST_WRITE;
                ST_FILL, ST_WRITE: begin
                    if (last_col) begin
                        x_cnt <= '0;
                        if (!last_row) y_cnt <= y_cnt + DIM_W'(1);
                    end else begin
                        x_cnt <= x_cnt + DIM_W'(1);
                    end
                    if (finish) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                        irq   <= irq_q;
                    end else if (state == ST_WRITE) begin
                        state <= ST_READ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        mem_en    = busy;
        mem_we    = advance;
        mem_addr  = (state == ST_READ) ? cur_ptr[CUR_SRC] : cur_ptr[CUR_DST];
        mem_wdata = (state == ST_WRITE) ? mem_rdata : colour_q;
    end

endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine
    import rbe_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    output logic              cmd_ready,
    input  logic [LINE_W-1:0] line_pixels,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PIX_W-1:0]  mem_wdata,
    input  logic [PIX_W-1:0]  mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              irq
);

    shape_t  shape;
    launch_t launch;

    assign cmd_ready = !busy;

    rbe_cmd_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .accept_en (cmd_ready),
        .cmd_word  (cmd_word),
        .shape     (shape),
        .launch    (launch)
    );

    rbe_walker #(.LINE_W(LINE_W)) u_walker (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .shape       (shape),
        .line_pixels (line_pixels),
        .mem_rdata   (mem_rdata),
        .mem_en      (mem_en),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .busy        (busy),
        .done        (done),
        .irq         (irq)
    );

endmodule

// File: rtl/rbe_checker.sv
module rbe_checker (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [31:0] cmd_word,
    input logic        cmd_ready,
    input logic        mem_en,
    input logic        mem_we,
    input logic [23:0] mem_addr,
    input logic        busy,
    input logic        done,
    input logic        irq
);

    logic       take;
    logic [7:0] op;
    logic       is_go;

    assign take  = cmd_valid && cmd_ready;
    assign op    = cmd_word[31:24];
    assign is_go = (op == 8'h21) || (op == 8'h23);

    assert_addr_even_R1: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> !mem_addr[0]);

    assert_go_busy_R4: assert property (@(posedge clk) disable iff (rst)
        (take && is_go) |=> busy);

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_en);

    assert_read_then_write_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !mem_we) |=> (mem_en && mem_we));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_at_end_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_irq_with_done_R5: assert property (@(posedge clk) disable iff (rst)
        irq |-> done);

    assert_drop_unknown_R7: assert property (@(posedge clk) disable iff (rst)
        (take && !is_go) |=> !busy);

endmodule

bind rect_blit_engine rbe_checker u_rbe_checker (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .cmd_ready (cmd_ready),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .busy      (busy),
    .done      (done),
    .irq       (irq)
);

// File: tb/sim_rect_blit_engine.sv
module sim_rect_blit_engine;

    localparam int CLK_PERIOD = 10;
    localparam int LINE_W     = 11;
    localparam int MEM_WORDS  = 4096;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [31:0]       cmd_word = '0;
    logic              cmd_ready;
    logic [LINE_W-1:0] line_pixels = LINE_W'(8);
    logic              mem_en, mem_we;
    logic [23:0]       mem_addr;
    logic [15:0]       mem_wdata;
    logic [15:0]       mem_rdata = '0;
    logic              busy, done, irq;

    int checks = 0;
    int failures = 0;

    typedef struct {
        bit          we;
        logic [23:0] addr;
        logic [15:0] data;
        string       tag;
    } access_t;

    access_t     expq[$];
    logic [15:0] model  [MEM_WORDS];
    logic [15:0] shadow [MEM_WORDS];

    logic [23:0] p_dst = '0, p_src = '0;
    int          p_w = 1, p_h = 1;
    logic [15:0] p_col = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rect_blit_engine #(.LINE_W(LINE_W)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .cmd_ready(cmd_ready), .line_pixels(line_pixels), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .irq(irq)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) model[mem_addr[12:1]] <= mem_wdata;
            else        mem_rdata <= model[mem_addr[12:1]];
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && mem_en) begin
            if (expq.size() == 0) begin
                check("R4 unexpected access", {7'd0, mem_we, mem_addr}, 32'hFFFFFFFF);
            end else begin
                access_t e;
                e = expq.pop_front();
                check({e.tag, " kind"}, {31'd0, mem_we}, {31'd0, e.we});
                check({e.tag, " addr"}, {8'd0, mem_addr}, {8'd0, e.addr});
                if (e.we) check({e.tag, " data"}, {16'd0, mem_wdata}, {16'd0, e.data});
            end
        end
    end

    task automatic send(logic [31:0] w);
        @(negedge clk);
        check("R4 ready before send", {31'd0, cmd_ready}, 32'd1);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    function automatic logic [23:0] pix_addr(logic [23:0] base, int x, int y);
        return base + 24'((y * int'(line_pixels) + x) * 2);
    endfunction

    task automatic run_go(bit copy, logic [31:0] flags, bit poke, string tag);
        int n = p_w * p_h;
        int cnt = 0;
        int expc = copy ? 2 * n : n;
        for (int y = 0; y < p_h; y++) begin
            for (int x = 0; x < p_w; x++) begin
                logic [23:0] da = pix_addr(p_dst, x, y);
                if (copy) begin
                    logic [23:0] sa = pix_addr(p_src, x, y);
                    logic [15:0] v = shadow[sa[12:1]];
                    expq.push_back('{1'b0, sa, 16'h0, {tag, " R3 read"}});
                    expq.push_back('{1'b1, da, v, {tag, " R3 write"}});
                    shadow[da[12:1]] = v;
                end else begin
                    expq.push_back('{1'b1, da, p_col, {tag, " R2 fill"}});
                    shadow[da[12:1]] = p_col;
                end
            end
        end
        send({copy ? 8'h21 : 8'h23, flags[23:0]});
        check({tag, " R4 busy after go"}, {31'd0, busy}, 32'd1);
        check({tag, " R4 ready low"}, {31'd0, cmd_ready}, 32'd0);
        if (poke) begin
            cmd_valid = 1'b1;
            cmd_word  = 32'h0C000F00;
        end
        while (!done && cnt < 20000) begin
            @(negedge clk);
            cnt++;
            if (poke && cnt == 1) begin
                check({tag, " R4 ready low on poke"}, {31'd0, cmd_ready}, 32'd0);
                cmd_valid = 1'b0;
            end
        end
        check({tag, " R5 done cycle"}, cnt, expc);
        check({tag, " R5 irq"}, {31'd0, irq}, {31'd0, flags[1]});
        check({tag, " R4 busy at done"}, {31'd0, busy}, 32'd0);
        @(negedge clk);
        check({tag, " R5 done one cycle"}, {31'd0, done}, 32'd0);
        check({tag, " R2 queue drained"}, expq.size(), 32'd0);
    endtask

    task automatic set_dst(logic [23:0] a);
        send({8'h0C, a}); p_dst = {a[23:1], 1'b0};
    endtask
    task automatic set_src(logic [23:0] a);
        send({8'h0D, a}); p_src = {a[23:1], 1'b0};
    endtask
    task automatic set_size(int w, int h);
        send({8'h0E, 14'd0, 10'(w - 1)}); p_w = w;
        send({8'h0F, 14'd0, 10'(h - 1)}); p_h = h;
    endtask
    task automatic set_col(logic [15:0] c);
        send({8'h0B, 8'd0, c}); p_col = c;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEM_WORDS; i++) begin
            model[i]  = 16'(i * 3) ^ 16'h5A5A;
            shadow[i] = 16'(i * 3) ^ 16'h5A5A;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 busy", {31'd0, busy}, 32'd0);
        check("R8 ready", {31'd0, cmd_ready}, 32'd1);
        check("R8 mem_en", {31'd0, mem_en}, 32'd0);
        check("R8 done", {31'd0, done}, 32'd0);
        check("R8 irq", {31'd0, irq}, 32'd0);

        // R1: odd destination address is aligned down; R2 fill with irq
        set_col(16'hF81F);
        set_dst(24'h000101);
        set_size(3, 2);
        run_go(1'b0, 32'h2, 1'b0, "T_fill_irq");

        // R3: copy filled area to another place, no irq
        set_src(24'h000100);
        set_dst(24'h000200);
        run_go(1'b1, 32'h0, 1'b0, "T_copy_fill");

        // R3 with background pattern, R4 word offered while busy is not taken
        set_src(24'h000600);
        set_dst(24'h000800);
        set_size(2, 3);
        run_go(1'b1, 32'h2, 1'b1, "T_copy_poke");

        // R6 retained parameters, R7 ignored start flag bits
        set_col(16'h07E0);
        run_go(1'b0, 32'h0000FC, 1'b0, "T_retain_R6_R7");

        // R7 unknown and out-of-scope opcodes are dropped
        send(32'h05123456);
        send(32'h22000003);
        send(32'h24000001);
        check("R7 no start", {31'd0, busy}, 32'd0);
        @(negedge clk);
        check("R7 still idle", {31'd0, busy}, 32'd0);
        set_dst(24'h000A01);
        set_size(1, 1);
        run_go(1'b0, 32'h0, 1'b0, "T_single_R7");

        // different line pitch
        line_pixels = LINE_W'(16);
        set_src(24'h000C00);
        set_dst(24'h000E00);
        set_size(3, 3);
        run_go(1'b1, 32'h0, 1'b0, "T_pitch16");
        set_size(1, 1);
        run_go(1'b1, 32'h2, 1'b0, "T_copy_single");

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule